// File: doc/BRIEF.md
# SMBus Register-Bank Slave

This block is a two-wire bus slave that gives a host read and write access to a bank of 8-bit control registers held in the surrounding core logic. It watches the clock and data lines, oversampled by the system clock after a synchronizer, and recognises START, repeated START and STOP conditions. It answers only to one fixed 7-bit device address. Data is open-drain: the block only ever pulls the data line low through an enable output.

One transfer engine handles four transaction shapes. After the address, the host sends a command code. Its top bit chooses between single-byte and count-prefixed block transfers, and its low bits give the first register index. Writes either store one byte or take a byte count followed by that many bytes, stored at consecutive indexes. Reads begin with a repeated START and an address with the read bit set. The block then returns either one register, or a byte count followed by consecutive registers. Each returned byte continues for as long as the host acknowledges it.

Toward the core, the register interface is an index, a write byte, a one-cycle write strobe and a read byte. The read byte is expected to follow the index combinationally.

Top module: `smb_regport`

## Requirements
- R1: The slave acknowledges an address byte by pulling SDA low in the ninth bit slot if and only if its upper seven bits equal DEV_ADDR. Bit 0 of the address byte is the direction: 0 means write and 1 means read.
- R2: After an address that does not match, the slave does not pull SDA low and issues no write strobe until the next START or STOP. A later matching transaction then works normally.
- R3: The byte after a matching write address is the command code, and the slave acknowledges it. Bit 7 of the command code selects block mode (1) or single-byte mode (0). Bits IDX_W-1:0 give the starting register index. Command bits between IDX_W and 6 are ignored.
- R4: In single-byte mode, the first data byte is acknowledged and written once. The write strobe is high for exactly one system clock, with reg_addr equal to the command index and reg_wdata equal to the byte.
- R5: In single-byte mode, any further data byte in the same write is not acknowledged and is not written.
- R6: In block mode, the first data byte is a count N and is acknowledged. The next N bytes are acknowledged and written to the start index, start+1, and so on, wrapping modulo 2**IDX_W. Bytes beyond N are not acknowledged and are not written.
- R7: In a single-byte read, the slave returns the register at the command index, most significant bit first. After the host answers with a NACK, the slave keeps SDA released.
- R8: In a block read, the slave first returns the byte count BLK_RD_LEN. It then returns the registers at consecutive indexes from the command index, for as long as the host acknowledges.
- R9: A repeated START restarts bit framing at the address byte and keeps the register index captured from the command code.
- R10: A STOP in the middle of a block write abandons the bytes still owed. The next transaction parses its second byte as a fresh command code.
- R11: While reset is asserted and after it is released, sda_oe and reg_we are low until a matching address is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | When high, pull the data line low |
| reg_addr | output | IDX_W | Register index for read or write |
| reg_wdata | output | 8 | Byte to store when reg_we is high |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Contents of the register at reg_addr |

## Verification
The acknowledge decision for a data byte and the register write strobe for that byte are both issued on the same system-clock cycle, the one that follows the falling SCL edge ending the eighth bit. In that cycle the write pointer also advances. The bench provokes this on the last counted byte of a block write that wraps past the top index, and on the first surplus byte after it. It judges the bus acknowledge bit it samples against the expected ACK or NACK. A scoreboard monitor separately pops the expected index and data for every strobe, so a write that comes with a NACK, or a NACK that comes with a write, shows as a miscompare.

// File: rtl/smb_pkg.sv
package smb_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CMD,
      PH_WDATA,
      PH_TX,
      PH_MACK,
      PH_SKIP
   } smb_phase_e;

endpackage

// File: rtl/smb_line_cond.sv
module smb_line_cond #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic sda_lvl,
   output logic start_det,
   output logic stop_det
);

   initial begin
      assert (SYNC_STAGES >= 2)
         else $error("smb_line_cond: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_pipe;
   logic [SYNC_STAGES-1:0] sda_pipe;
   logic                   scl_now, sda_now;
   logic                   scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
         scl_q    <= scl_now;
         sda_q    <= sda_now;
      end
   end

   assign scl_now   = scl_pipe[SYNC_STAGES-1];
   assign sda_now   = sda_pipe[SYNC_STAGES-1];
   assign scl_rise  = scl_now & ~scl_q;
   assign scl_fall  = ~scl_now & scl_q;
   assign sda_lvl   = sda_now;
   assign start_det = scl_now & scl_q & sda_q & ~sda_now;
   assign stop_det  = scl_now & scl_q & ~sda_q & sda_now;

endmodule

// File: rtl/smb_reg_ptr.sv
module smb_reg_ptr #(
   parameter int unsigned IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);

   localparam logic [IDX_W-1:0] STEP = IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (ld)  ptr <= ld_idx;
      else if (adv) ptr <= ptr + STEP;
   end

   // R3: a command load never coincides with a sequential advance
   p_ld_adv_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld && adv));

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
   import smb_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR   = 7'h69,
   parameter int unsigned IDX_W      = 5,
   parameter int unsigned BLK_RD_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_lvl,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [IDX_W-1:0] ptr,
   input  logic [7:0]       rd_byte,
   output logic             sda_oe,
   output logic             ptr_ld,
   output logic [IDX_W-1:0] ptr_ld_idx,
   output logic             ptr_adv,
   output logic             wr_stb,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_byte
);

   localparam logic [7:0] CNT_BYTE = 8'(BLK_RD_LEN);
   localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 7)
         else $error("smb_xfer_fsm: IDX_W must be 1..7");
      assert (BLK_RD_LEN >= 1 && BLK_RD_LEN <= 255)
         else $error("smb_xfer_fsm: BLK_RD_LEN must be 1..255");
   end

   smb_phase_e phase;
   logic [3:0] cnt;
   logic [7:0] sh, tx, remain, nxt_tx;
   logic       oe, in_ack, blk, first, send_cnt, got_ack, rx_phase;

   always_comb begin
      rx_phase = (phase == PH_ADDR) || (phase == PH_CMD) || (phase == PH_WDATA);
      nxt_tx   = send_cnt ? CNT_BYTE : rd_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cnt        <= '0;
         sh         <= '0;
         tx         <= '0;
         remain     <= '0;
         oe         <= 1'b0;
         in_ack     <= 1'b0;
         blk        <= 1'b0;
         first      <= 1'b0;
         send_cnt   <= 1'b0;
         got_ack    <= 1'b0;
         ptr_ld     <= 1'b0;
         ptr_ld_idx <= '0;
         ptr_adv    <= 1'b0;
         wr_stb     <= 1'b0;
         wr_idx     <= '0;
         wr_byte    <= '0;
      end else begin
         ptr_ld  <= 1'b0;
         ptr_adv <= 1'b0;
         wr_stb  <= 1'b0;
         if (start_det) begin
            phase  <= PH_ADDR;
            cnt    <= '0;
            in_ack <= 1'b0;
            oe     <= 1'b0;
         end else if (stop_det) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            in_ack <= 1'b0;
            oe     <= 1'b0;
         end else if (scl_rise) begin
            if (!in_ack) begin
               if (rx_phase) begin
                  sh  <= {sh[6:0], sda_lvl};
                  cnt <= cnt + 4'd1;
               end else if (phase == PH_TX) begin
                  cnt <= cnt + 4'd1;
               end else if (phase == PH_MACK) begin
                  got_ack <= ~sda_lvl;
               end
            end
         end else if (scl_fall) begin
            if (in_ack) begin
               in_ack <= 1'b0;
               cnt    <= '0;
               if (phase == PH_TX) begin
                  tx <= nxt_tx;
                  oe <= ~nxt_tx[7];
                  if (send_cnt) send_cnt <= 1'b0;
                  else          ptr_adv  <= 1'b1;
               end else begin
                  oe <= 1'b0;
               end
            end else if (rx_phase && cnt == LAST_BIT) begin
               cnt <= '0;
               case (phase)
                  PH_ADDR: begin
                     if (sh[7:1] == DEV_ADDR) begin
                        in_ack <= 1'b1;
                        oe     <= 1'b1;
                        if (sh[0]) begin
                           phase    <= PH_TX;
                           send_cnt <= blk;
                        end else begin
                           phase <= PH_CMD;
                        end
                     end else begin
                        phase <= PH_SKIP;
                     end
                  end
                  PH_CMD: begin
                     blk        <= sh[7];
                     ptr_ld     <= 1'b1;
                     ptr_ld_idx <= sh[IDX_W-1:0];
                     first      <= 1'b1;
                     remain     <= '0;
                     in_ack     <= 1'b1;
                     oe         <= 1'b1;
                     phase      <= PH_WDATA;
                  end
                  PH_WDATA: begin
                     in_ack <= 1'b1;
                     if (first && blk) begin
                        remain <= sh;
                        first  <= 1'b0;
                        oe     <= 1'b1;
                     end else if (first || remain != 8'd0) begin
                        wr_stb  <= 1'b1;
                        wr_idx  <= ptr;
                        wr_byte <= sh;
                        ptr_adv <= 1'b1;
                        first   <= 1'b0;
                        if (!first) remain <= remain - 8'd1;
                        oe      <= 1'b1;
                     end else begin
                        oe <= 1'b0;
                     end
                  end
                  default: ;
               endcase
            end else if (phase == PH_TX) begin
               if (cnt == LAST_BIT) begin
                  oe      <= 1'b0;
                  cnt     <= '0;
                  got_ack <= 1'b0;
                  phase   <= PH_MACK;
               end else begin
                  tx <= {tx[6:0], 1'b0};
                  oe <= ~tx[6];
               end
            end else if (phase == PH_MACK) begin
               if (got_ack) begin
                  phase <= PH_TX;
                  cnt   <= '0;
                  tx    <= nxt_tx;
                  oe    <= ~nxt_tx[7];
                  if (send_cnt) send_cnt <= 1'b0;
                  else          ptr_adv  <= 1'b1;
               end else begin
                  phase <= PH_SKIP;
                  oe    <= 1'b0;
               end
            end
         end
      end
   end

   assign sda_oe = oe;

   // R2: an unaddressed slave neither drives the bus nor writes
   p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP) |-> (!oe && !wr_stb));

   // R11: no drive while the bus is idle
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !oe);

   // R4: the write strobe is a single-cycle pulse
   p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R6: writes only occur while a data byte is being acknowledged
   p_we_in_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (phase == PH_WDATA && in_ack));

   // R1: the data line only changes after an SCL fall or a bus condition
   p_oe_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe) |-> $past(scl_fall || start_det || stop_det));

endmodule

// File: rtl/smb_regport.sv
module smb_regport #(
   parameter logic [6:0]  DEV_ADDR    = 7'h69,
   parameter int unsigned IDX_W       = 5,
   parameter int unsigned BLK_RD_LEN  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic [IDX_W-1:0] reg_addr,
   output logic [7:0]       reg_wdata,
   output logic             reg_we,
   input  logic [7:0]       reg_rdata
);

   logic             scl_rise, scl_fall, sda_lvl, start_det, stop_det;
   logic             ptr_ld, ptr_adv, wr_stb;
   logic [IDX_W-1:0] ptr_ld_idx, ptr, wr_idx;
   logic [7:0]       wr_byte;

   smb_line_cond #(
      .SYNC_STAGES(SYNC_STAGES)
   ) i_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .sda_lvl  (sda_lvl),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   smb_reg_ptr #(
      .IDX_W(IDX_W)
   ) i_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ptr_ld),
      .ld_idx(ptr_ld_idx),
      .adv   (ptr_adv),
      .ptr   (ptr)
   );

   smb_xfer_fsm #(
      .DEV_ADDR  (DEV_ADDR),
      .IDX_W     (IDX_W),
      .BLK_RD_LEN(BLK_RD_LEN)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_lvl   (sda_lvl),
      .start_det (start_det),
      .stop_det  (stop_det),
      .ptr       (ptr),
      .rd_byte   (reg_rdata),
      .sda_oe    (sda_oe),
      .ptr_ld    (ptr_ld),
      .ptr_ld_idx(ptr_ld_idx),
      .ptr_adv   (ptr_adv),
      .wr_stb    (wr_stb),
      .wr_idx    (wr_idx),
      .wr_byte   (wr_byte)
   );

   assign reg_addr  = wr_stb ? wr_idx : ptr;
   assign reg_wdata = wr_byte;
   assign reg_we    = wr_stb;

endmodule

// File: tb/test_smb_regport.sv
module test_smb_regport;

   localparam int         CLK_PERIOD = 10;
   localparam int         QCLK       = 10;
   localparam logic [6:0] DEV        = 7'h69;
   localparam int         IDX_W      = 5;
   localparam int         NREG       = 32;
   localparam int         BLK        = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             scl_m = 1'b1;
   logic             sda_m = 1'b1;
   logic             sda_oe, reg_we;
   logic [IDX_W-1:0] reg_addr;
   logic [7:0]       reg_wdata, reg_rdata;
   logic [7:0]       regs [NREG];
   logic [7:0]       shadow [NREG];
   wire              bus_sda = sda_m & ~sda_oe;

   typedef struct packed {
      logic [IDX_W-1:0] a;
      logic [7:0]       d;
   } wr_t;
   wr_t wq[$];

   int checks = 0;
   int fails  = 0;

   smb_regport #(
      .DEV_ADDR(DEV), .IDX_W(IDX_W), .BLK_RD_LEN(BLK), .SYNC_STAGES(2)
   ) i_smb_regport (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (reg_we) regs[reg_addr] <= reg_wdata;
   assign reg_rdata = regs[reg_addr];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: every strobe must match the next queued write
   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         if (wq.size() == 0) begin
            chk("R2 R5 stray write strobe", 32'(reg_addr), 32'hFFFF);
         end else begin
            wr_t e;
            e = wq.pop_front();
            chk("R4 R6 write index", 32'(reg_addr), 32'(e.a));
            chk("R4 R6 write data", 32'(reg_wdata), 32'(e.d));
         end
      end
   end

   task automatic qwait();
      repeat (QCLK) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; qwait();
      sda_m = 1'b0; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b0; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b1; qwait(); qwait();
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; qwait();
      scl_m = 1'b1; qwait(); qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; qwait();
      scl_m = 1'b1; qwait();
      b = bus_sda; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ackbit);
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(ackbit);
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic master_ack);
      for (int i = 7; i >= 0; i--) bit_in(v[i]);
      bit_out(master_ack ? 1'b0 : 1'b1);
   endtask

   task automatic push_wr(input int idx, input logic [7:0] d);
      wr_t e;
      e.a = IDX_W'(idx);
      e.d = d;
      wq.push_back(e);
      shadow[idx] = d;
   endtask

   task automatic wr_single(input logic [7:0] cmd, input logic [7:0] d);
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R1 write address ack", 32'(a), 32'd0);
      send_byte(cmd, a);         chk("R3 command ack", 32'(a), 32'd0);
      push_wr(int'(cmd[IDX_W-1:0]), d);
      send_byte(d, a);           chk("R4 data ack", 32'(a), 32'd0);
      bus_stop();
   endtask

   task automatic rd_single(input logic [7:0] cmd, output logic [7:0] v);
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R1 address ack before read", 32'(a), 32'd0);
      send_byte(cmd, a);         chk("R3 command ack before read", 32'(a), 32'd0);
      bus_rstart();
      send_byte({DEV, 1'b1}, a); chk("R9 read address ack after repeated START", 32'(a), 32'd0);
      recv_byte(v, 1'b0);
      qwait();
      chk("R7 SDA released after NACK", 32'(sda_oe), 32'd0);
      bus_stop();
   endtask

   initial begin
      logic       a;
      logic [7:0] v;
      repeat (5) @(negedge clk);
      chk("R11 sda_oe in reset", 32'(sda_oe), 32'd0);
      chk("R11 reg_we in reset", 32'(reg_we), 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R11 sda_oe after reset", 32'(sda_oe), 32'd0);

      // single write with a surplus byte
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R1 address ack", 32'(a), 32'd0);
      send_byte(8'h03, a);       chk("R3 command ack", 32'(a), 32'd0);
      push_wr(3, 8'hA5);
      send_byte(8'hA5, a);       chk("R4 single data ack", 32'(a), 32'd0);
      send_byte(8'h77, a);       chk("R5 surplus byte NACK", 32'(a), 32'd1);
      bus_stop();

      rd_single(8'h03, v);
      chk("R7 single read data", 32'(v), 32'hA5);
      rd_single(8'h63, v);
      chk("R3 upper command bits ignored", 32'(v), 32'hA5);

      // block write wrapping past the top index, then one extra byte
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R1 address ack block write", 32'(a), 32'd0);
      send_byte(8'h9E, a);       chk("R3 block command ack", 32'(a), 32'd0);
      send_byte(8'd4, a);        chk("R6 count ack", 32'(a), 32'd0);
      for (int i = 0; i < 4; i++) begin
         push_wr((30 + i) % NREG, 8'(8'h11 * (i + 1)));
         send_byte(8'(8'h11 * (i + 1)), a);
         chk("R6 block data ack", 32'(a), 32'd0);
      end
      send_byte(8'h55, a);       chk("R6 byte beyond count NACK", 32'(a), 32'd1);
      bus_stop();

      // block read
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R1 address ack block read", 32'(a), 32'd0);
      send_byte(8'h9E, a);       chk("R3 block read command ack", 32'(a), 32'd0);
      bus_rstart();
      send_byte({DEV, 1'b1}, a); chk("R9 read address ack", 32'(a), 32'd0);
      recv_byte(v, 1'b1);
      chk("R8 block read count", 32'(v), 32'(BLK));
      for (int i = 0; i < BLK; i++) begin
         recv_byte(v, i != BLK - 1);
         chk("R8 block read data", 32'(v), 32'(shadow[(30 + i) % NREG]));
      end
      qwait();
      chk("R7 release after final NACK", 32'(sda_oe), 32'd0);
      bus_stop();

      // foreign address: nothing acknowledged, nothing written
      bus_start();
      send_byte({7'h12, 1'b0}, a); chk("R2 foreign address not acked", 32'(a), 32'd1);
      send_byte(8'h05, a);         chk("R2 ignored byte not acked", 32'(a), 32'd1);
      send_byte(8'h99, a);         chk("R2 ignored byte not acked", 32'(a), 32'd1);
      bus_stop();
      wr_single(8'h05, 8'h3C);
      rd_single(8'h05, v);
      chk("R2 R9 normal access after foreign address", 32'(v), 32'h3C);
      rd_single(8'h03, v);
      chk("R2 register untouched by foreign traffic", 32'(v), 32'hA5);

      // STOP in the middle of a block write
      bus_start();
      send_byte({DEV, 1'b0}, a); chk("R1 address ack aborted block", 32'(a), 32'd0);
      send_byte(8'h8A, a);       chk("R3 block command ack", 32'(a), 32'd0);
      send_byte(8'd3, a);        chk("R6 count ack", 32'(a), 32'd0);
      push_wr(10, 8'h5A);
      send_byte(8'h5A, a);       chk("R10 first block byte ack", 32'(a), 32'd0);
      bus_stop();
      wr_single(8'h0C, 8'h66);
      rd_single(8'h0C, v);
      chk("R10 fresh command after aborted block", 32'(v), 32'h66);
      rd_single(8'h0A, v);
      chk("R10 byte stored before STOP", 32'(v), 32'h5A);

      repeat (20) @(negedge clk);
      chk("R6 all expected writes seen", 32'(wq.size()), 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule